// File: doc/BRIEF.md
# L2 Bucket Hash Generator

This block turns a forwarding-table lookup key into an 11-bit bucket index for the layer-2 address table. The key joins a 12-bit VLAN/filtering identifier with a 48-bit station address. The identifier sits in the low 12 bits and the address above it. The 60-bit key is zero-padded to a 64-bit seed. The seed is cut into six slices on 11-bit boundaries. The five lower slices are 11 bits wide. The top slice, bits 63 down to 55, is 9 bits wide and is zero-extended to 11 bits. The bucket index is the XOR of the six slices.

A mode input picks one of two fold algorithms. In the plain fold, every slice goes into the XOR unchanged. In the rotating fold, three slices are rotated first so that similar keys spread further apart. The rotated slices are seed bits 21:11, 43:33 and 54:44. Each of the three uses a different rotation amount. The mode bit is sampled in the same cycle as the key. A valid strobe travels alongside the key, and the result appears on a registered output one clock later.

Top module: `l2_bucket_hash`

## Requirements
- R1: While rst_n is low at a rising clock edge, out_valid becomes 0 and out_hash becomes 0 after that edge.
- R2: out_valid after a rising edge equals in_valid sampled at that edge, giving one cycle of latency.
- R3: With in_alt_mode = 0 at the sampling edge, out_hash is the XOR of the six seed slices. The seed is {4'b0, in_mac, in_fid}. The slices are seed[10:0], [21:11], [32:22], [43:33], [54:44] and the zero-extended seed[63:55].
- R4: With in_alt_mode = 1, out_hash is the XOR of the same six slices after three rotations. Slice s = seed[21:11] becomes {s[4:0], s[10:5]}. Slice seed[43:33] becomes {s[5:0], s[10:6]}. Slice seed[54:44] becomes {s[6:0], s[10:7]}. The other three slices are used unrotated.
- R5: The mode bit is captured together with the key. A change of in_alt_mode in a later cycle does not alter a hash that has already been produced.
- R6: When in_valid is 0 at a rising edge, out_hash keeps its previous value.
- R7: The identifier occupies seed bits 11:0 and the address occupies seed bits 59:12. For example, in_fid = 12'h800 with a zero address gives hash 0x001 in the plain fold and 0x040 in the rotating fold. in_mac bit 47 alone gives 0x010 in both modes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Key strobe |
| in_fid | input | 12 | VLAN/filtering identifier, low part of the key |
| in_mac | input | 48 | Station address, high part of the key |
| in_alt_mode | input | 1 | 0 selects the plain fold, 1 selects the rotating fold |
| out_valid | output | 1 | Hash strobe, one cycle after in_valid |
| out_hash | output | 11 | Bucket index |

## Verification
The assertions assume that in_valid, in_alt_mode and the key inputs are settled before each rising edge. They also assume that rst_n is held low for at least one edge before any traffic. The stimulus meets both assumptions by holding reset low for several cycles and by changing every input on the falling edge. Because the key is arbitrary data, the rotation checks rely on a property that holds for any key: a rotation keeps the number of set bits. The fold value itself is compared by the bench against a model written from the slice formulas. The bench also checks single-bit keys whose bucket index can be worked out by hand.

// File: rtl/l2h_pkg.sv
// Package l2h_pkg
// Purpose: shared sizes and the per-slice rotation table for the bucket hash.
// Assumes: slices are numbered from the least significant end of the seed.
package l2h_pkg;

    localparam int unsigned HASH_W = 11;

    // Number of low bits moved to the top of slice idx in the rotating fold (0 = none).
    function automatic int unsigned rot_low_bits(input int unsigned idx);
        case (idx)
            1:       return 5;
            3:       return 6;
            4:       return 7;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/l2h_slicer.sv
// Module l2h_slicer
// Purpose: cuts a zero-padded seed into NUM_SLICES fields of SLICE_W bits.
// Assumes: SEED_W <= NUM_SLICES*SLICE_W; bits above SEED_W read as zero.
module l2h_slicer #(
    parameter int unsigned SEED_W     = 64,
    parameter int unsigned SLICE_W    = 11,
    parameter int unsigned NUM_SLICES = 6
) (
    input  logic [SEED_W-1:0]                  seed,
    output logic [NUM_SLICES-1:0][SLICE_W-1:0] slices
);

    localparam int unsigned PAD_W = NUM_SLICES * SLICE_W;

    logic [PAD_W-1:0] padded;

    // Zero-extend the seed so that the top slice is filled with zeros.
    always_comb begin
        padded = '0;
        padded[SEED_W-1:0] = seed;
    end

    // One field per slice position.
    for (genvar i = 0; i < NUM_SLICES; i++) begin : g_slice
        assign slices[i] = padded[i*SLICE_W +: SLICE_W];
    end

endmodule

// File: rtl/l2h_rotator.sv
// Module l2h_rotator
// Purpose: when alt is set, moves the LOW_BITS least significant bits of a
//          slice to its top; otherwise passes the slice through.
// Assumes: 0 < LOW_BITS < WIDTH.
module l2h_rotator #(
    parameter int unsigned WIDTH    = 11,
    parameter int unsigned LOW_BITS = 5
) (
    input  logic             alt,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] rotated;

    // Rotated form of the slice.
    assign rotated = {din[LOW_BITS-1:0], din[WIDTH-1:LOW_BITS]};

    // Select rotated or plain slice.
    assign dout = alt ? rotated : din;

    // A rotation moves bits and never creates or drops any (R4).
    always_comb begin
        assert_rot_popcount_R4: assert ($countones(dout) == $countones(din));
    end

endmodule

// File: rtl/l2h_fold.sv
// Module l2h_fold
// Purpose: XOR-reduces NUM_SLICES fields of WIDTH bits into one field.
// Assumes: any rotations are applied to the fields before they arrive.
module l2h_fold #(
    parameter int unsigned WIDTH      = 11,
    parameter int unsigned NUM_SLICES = 6
) (
    input  logic [NUM_SLICES-1:0][WIDTH-1:0] fields,
    output logic [WIDTH-1:0]                 folded
);

    // Accumulate the XOR of every field.
    always_comb begin
        folded = '0;
        for (int i = 0; i < NUM_SLICES; i++) begin
            folded = folded ^ fields[i];
        end
    end

endmodule

// File: rtl/l2_bucket_hash.sv
// Module l2_bucket_hash
// Purpose: forms the seed {MAC, FID}, slices it, optionally rotates three
//          slices, XOR-folds them and registers the bucket index.
// Assumes: inputs settle before the rising edge; the mode bit applies to the
//          key presented in the same cycle. Latency is one clock.
module l2_bucket_hash #(
    parameter int unsigned FID_W  = 12,
    parameter int unsigned MAC_W  = 48,
    parameter int unsigned SEED_W = 64
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic [FID_W-1:0]         in_fid,
    input  logic [MAC_W-1:0]         in_mac,
    input  logic                     in_alt_mode,
    output logic                     out_valid,
    output logic [l2h_pkg::HASH_W-1:0] out_hash
);

    import l2h_pkg::*;

    localparam int unsigned KEY_W      = FID_W + MAC_W;
    localparam int unsigned NUM_SLICES = (SEED_W + HASH_W - 1) / HASH_W;

    logic [SEED_W-1:0]                 seed;
    logic [NUM_SLICES-1:0][HASH_W-1:0] raw_slices;
    logic [NUM_SLICES-1:0][HASH_W-1:0] mixed_slices;
    logic [HASH_W-1:0]                 hash_next;

    // Build the seed: identifier low, address above it, zeros on top.
    always_comb begin
        seed = '0;
        seed[KEY_W-1:0] = {in_mac, in_fid};
    end

    l2h_slicer #(
        .SEED_W    (SEED_W),
        .SLICE_W   (HASH_W),
        .NUM_SLICES(NUM_SLICES)
    ) u_slicer (
        .seed  (seed),
        .slices(raw_slices)
    );

    // Rotate the slices the rotating fold names; pass the rest through.
    for (genvar i = 0; i < NUM_SLICES; i++) begin : g_mix
        if (rot_low_bits(i) == 0) begin : g_plain
            assign mixed_slices[i] = raw_slices[i];
        end else begin : g_rot
            l2h_rotator #(
                .WIDTH   (HASH_W),
                .LOW_BITS(rot_low_bits(i))
            ) u_rot (
                .alt (in_alt_mode),
                .din (raw_slices[i]),
                .dout(mixed_slices[i])
            );
        end
    end

    l2h_fold #(
        .WIDTH     (HASH_W),
        .NUM_SLICES(NUM_SLICES)
    ) u_fold (
        .fields(mixed_slices),
        .folded(hash_next)
    );

    // Output strobe register.
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= in_valid;
    end

    // Output hash register, loaded only with a valid key.
    always_ff @(posedge clk) begin
        if (!rst_n)        out_hash <= '0;
        else if (in_valid) out_hash <= hash_next;
    end

    // Reset clears both outputs (R1).
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_hash == '0));

    // A valid key yields a valid hash one cycle later (R2).
    assert_valid_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // No key means no hash strobe one cycle later (R2).
    assert_valid_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // An idle cycle leaves the hash unchanged (R6).
    assert_hash_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_hash));

endmodule

// File: tb/l2_bucket_hash_tb.sv
module l2_bucket_hash_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [11:0] in_fid;
    logic [47:0] in_mac;
    logic        in_alt_mode;
    logic        out_valid;
    logic [10:0] out_hash;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    l2_bucket_hash u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_fid     (in_fid),
        .in_mac     (in_mac),
        .in_alt_mode(in_alt_mode),
        .out_valid  (out_valid),
        .out_hash   (out_hash)
    );

    // Reference model written from the slice formulas of R3 and R4.
    function automatic logic [10:0] ref_hash(input logic [47:0] mac,
                                             input logic [11:0] fid,
                                             input logic alt);
        logic [63:0] sd;
        logic [10:0] a, b, c, d, e, f;
        sd = {4'b0, mac, fid};
        a = sd[10:0];
        b = sd[21:11];
        c = sd[32:22];
        d = sd[43:33];
        e = sd[54:44];
        f = {2'b0, sd[63:55]};
        if (alt) begin
            b = {b[4:0], b[10:5]};
            d = {d[5:0], d[10:6]};
            e = {e[6:0], e[10:7]};
        end
        return a ^ b ^ c ^ d ^ e ^ f;
    endfunction

    task automatic check(input string req, input logic [10:0] act, input logic [10:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one key on the falling edge, then sample after the next rising edge.
    task automatic push(input logic v, input logic [11:0] fid, input logic [47:0] mac,
                        input logic alt);
        @(negedge clk);
        in_valid = v; in_fid = fid; in_mac = mac; in_alt_mode = alt;
        @(posedge clk);
        #1;
    endtask

    task automatic test_reset();
        rst_n = 1'b0;
        push(1'b1, 12'hfff, 48'hffff_ffff_ffff, 1'b1);
        check("R1 valid", {10'b0, out_valid}, 11'd0);
        check("R1 hash", out_hash, 11'd0);
        @(negedge clk);
        rst_n = 1'b1;
        in_valid = 1'b0;
    endtask

    task automatic test_known_bits();
        push(1'b1, 12'h800, 48'h0, 1'b0);
        check("R7 fid11 plain", out_hash, 11'h001);
        push(1'b1, 12'h800, 48'h0, 1'b1);
        check("R7 fid11 rot", out_hash, 11'h040);
        push(1'b1, 12'h000, 48'h1, 1'b1);
        check("R7 mac0 rot", out_hash, 11'h080);
        push(1'b1, 12'h000, 48'h8000_0000_0000, 1'b0);
        check("R7 mac47 plain", out_hash, 11'h010);
        push(1'b1, 12'h000, 48'h8000_0000_0000, 1'b1);
        check("R7 mac47 rot", out_hash, 11'h010);
    endtask

    task automatic test_plain_fold();
        logic [47:0] m;
        logic [11:0] f;
        m = 48'h0123_4567_89ab; f = 12'h5a5;
        for (int i = 0; i < 20; i++) begin
            push(1'b1, f, m, 1'b0);
            check("R3 plain", out_hash, ref_hash(m, f, 1'b0));
            check("R2 valid", {10'b0, out_valid}, 11'd1);
            m = {m[46:0], m[47] ^ m[42]} ^ 48'h9e37_79b9_7f4a;
            f = f * 12'd37 + 12'd11;
        end
    endtask

    task automatic test_rot_fold();
        logic [47:0] m;
        logic [11:0] f;
        m = 48'hfedc_ba98_7654; f = 12'h3c1;
        for (int i = 0; i < 20; i++) begin
            push(1'b1, f, m, 1'b1);
            check("R4 rot", out_hash, ref_hash(m, f, 1'b1));
            m = {m[44:0], m[47:45]} + 48'h1357_9bdf_2468;
            f = f ^ {f[10:0], f[11]};
        end
        push(1'b1, 12'hfff, 48'hffff_ffff_ffff, 1'b1);
        check("R4 all ones", out_hash, ref_hash(48'hffff_ffff_ffff, 12'hfff, 1'b1));
    endtask

    task automatic test_mode_capture();
        logic [10:0] held;
        push(1'b1, 12'h800, 48'h0, 1'b1);
        held = out_hash;
        check("R5 captured rot", held, 11'h040);
        push(1'b0, 12'h800, 48'h0, 1'b0);
        check("R5 after mode change", out_hash, 11'h040);
        check("R2 idle valid", {10'b0, out_valid}, 11'd0);
    endtask

    task automatic test_hold();
        push(1'b1, 12'h123, 48'h0000_0000_0abc, 1'b0);
        check("R6 load", out_hash, ref_hash(48'h0000_0000_0abc, 12'h123, 1'b0));
        for (int i = 0; i < 3; i++) begin
            push(1'b0, 12'hfff - 12'(i), 48'hdead_beef_0000, 1'b1);
            check("R6 hold", out_hash, ref_hash(48'h0000_0000_0abc, 12'h123, 1'b0));
            check("R2 no strobe", {10'b0, out_valid}, 11'd0);
        end
    endtask

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; in_fid = '0; in_mac = '0; in_alt_mode = 1'b0;
        repeat (3) @(posedge clk);
        test_reset();
        test_known_bits();
        test_plain_fold();
        test_rot_fold();
        test_mode_capture();
        test_hold();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 5000);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule